// File: doc/BRIEF.md
# Conditional Branch and Counted Loop Unit

This unit chooses the next instruction pointer for conditional jumps and counted loops. Each enabled cycle takes a 5-bit selector, the four condition flags (sign, zero, overflow, carry), the sequential next address and a precomputed branch target. It registers either the target or the sequential address as the new instruction pointer. Sixteen selector codes evaluate flag conditions. Three further codes decrement an internal count register and branch while the new count is nonzero, with an optional test of the zero flag.

The pointer register and the count register both live inside the block. A separate load port seeds the count before a loop. A one-cycle write-enable output marks every cycle in which a loop form wrote the count. The block has no state machine. Its only sequential state is the pointer register, the count register and the write-enable flag, and all three share one reset and one update process. Fetch, decode and target computation are done elsewhere.

Top module: `brl_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `next_ip` is 0, `count` is 0 and `count_we` is 0.
- R2: Selector codes 0..7 test a single flag. 0 is S=1, 1 is S=0, 2 is Z=1, 3 is Z=0, 4 is O=1, 5 is O=0, 6 is C=1 and 7 is C=0. A true condition loads `tgt_addr` into `next_ip`, otherwise `seq_addr` is loaded.
- R3: Code 8 (unsigned above) is true when (C OR Z) is 0. Code 9 (unsigned below-or-equal) is true when (C OR Z) is 1.
- R4: Code 10 (signed less) is true when S XOR O is 1. Code 11 (signed greater-or-equal) is true when S XOR O is 0.
- R5: Code 12 (signed greater) is true when Z OR (S XOR O) is 0. Code 13 (signed less-or-equal) is true when that expression is 1.
- R6: Code 14 is always true and code 15 is never true. Codes 0..15 leave `count` unchanged.
- R7: Code 16 (plain loop) writes `count`-1 to `count` and branches when that new value is nonzero.
- R8: Code 17 (loop while zero) decrements the count and branches when the new count is nonzero and Z is 1.
- R9: Code 18 (loop while not zero) decrements the count and branches when the new count is nonzero and Z is 0.
- R10: A count of 1 decrements to 0 and falls through to `seq_addr`. A count of 0 wraps to all ones and branches.
- R11: With `en` low and `cnt_ld` low, `next_ip`, `count` are held and `count_we` is 0.
- R12: `count_we` is 1 in the cycle after an enabled loop code (16..18) and 0 otherwise. Codes 19..31 load `seq_addr` and leave `count` unchanged.
- R13: `cnt_ld` high loads `cnt_ld_val` into `count` and holds `next_ip`, whatever `en` and `sel` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Clock enable for a branch or loop decision |
| sel | input | 5 | Condition or loop selector |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| flag_o | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| seq_addr | input | AW | Sequential next address |
| tgt_addr | input | AW | Branch target address |
| cnt_ld | input | 1 | Load the count register |
| cnt_ld_val | input | CW | Value to load into the count |
| next_ip | output | AW | Registered next instruction pointer |
| count | output | CW | Registered count register |
| count_we | output | 1 | Count was written by a loop form last cycle |

## Verification
Every result is registered once. A selector applied before a rising edge shows up on `next_ip`, `count` and `count_we` right after that edge, and nothing arrives later than one cycle. The bench drives inputs on the falling edge and advances a behavioural model at the rising edge. It compares all three outputs at the next falling edge, so each vector is judged exactly one cycle after it was applied. Loop runs are chained across cycles, which checks that each decrement builds on the count left by the one before.

// File: rtl/brl_pkg.sv
package brl_pkg;
    typedef enum logic [4:0] {
        SEL_S      = 5'd0,
        SEL_NS     = 5'd1,
        SEL_Z      = 5'd2,
        SEL_NZ     = 5'd3,
        SEL_O      = 5'd4,
        SEL_NO     = 5'd5,
        SEL_C      = 5'd6,
        SEL_NC     = 5'd7,
        SEL_ABOVE  = 5'd8,
        SEL_BE     = 5'd9,
        SEL_LT     = 5'd10,
        SEL_GE     = 5'd11,
        SEL_GT     = 5'd12,
        SEL_LE     = 5'd13,
        SEL_ALWAYS = 5'd14,
        SEL_NEVER  = 5'd15,
        SEL_LOOP   = 5'd16,
        SEL_LOOPE  = 5'd17,
        SEL_LOOPNE = 5'd18
    } sel_e;

    typedef enum logic [1:0] {
        LF_PLAIN  = 2'd0,
        LF_WHILEZ = 2'd1,
        LF_WHILENZ = 2'd2
    } loop_form_e;
endpackage

// File: rtl/brl_cond_eval.sv
module brl_cond_eval (
    input  logic [3:0] code,
    input  logic       fs,
    input  logic       fz,
    input  logic       fo,
    input  logic       fc,
    output logic       take
);
    logic sgn_lt;
    logic uns_be;

    always_comb begin
        sgn_lt = fs ^ fo;
        uns_be = fc | fz;
        case (code)
            4'd0:    take = fs;
            4'd1:    take = ~fs;
            4'd2:    take = fz;
            4'd3:    take = ~fz;
            4'd4:    take = fo;
            4'd5:    take = ~fo;
            4'd6:    take = fc;
            4'd7:    take = ~fc;
            4'd8:    take = ~uns_be;
            4'd9:    take = uns_be;
            4'd10:   take = sgn_lt;
            4'd11:   take = ~sgn_lt;
            4'd12:   take = ~(fz | sgn_lt);
            4'd13:   take = fz | sgn_lt;
            4'd14:   take = 1'b1;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/brl_loop_dec.sv
module brl_loop_dec #(
    parameter int CW = 32
) (
    input  logic [CW-1:0] cnt_cur,
    input  logic [1:0]    form,
    input  logic          fz,
    output logic [CW-1:0] cnt_next,
    output logic          take
);
    import brl_pkg::*;

    logic still_running;
    logic zf_ok;

    always_comb begin
        cnt_next      = cnt_cur - CW'(1);
        still_running = |cnt_next;
        case (form)
            LF_WHILEZ:  zf_ok = fz;
            LF_WHILENZ: zf_ok = ~fz;
            default:    zf_ok = 1'b1;
        endcase
        take = still_running & zf_ok;
    end
endmodule

// File: rtl/brl_unit.sv
module brl_unit #(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [4:0]    sel,
    input  logic          flag_s,
    input  logic          flag_z,
    input  logic          flag_o,
    input  logic          flag_c,
    input  logic [AW-1:0] seq_addr,
    input  logic [AW-1:0] tgt_addr,
    input  logic          cnt_ld,
    input  logic [CW-1:0] cnt_ld_val,
    output logic [AW-1:0] next_ip,
    output logic [CW-1:0] count,
    output logic          count_we
);
    import brl_pkg::*;

    logic [AW-1:0] ip_q;
    logic [CW-1:0] cnt_q;
    logic          we_q;
    logic          past_ok;

    logic          is_cond;
    logic          is_loop;
    logic [1:0]    form;
    logic          cond_take;
    logic          loop_take;
    logic [CW-1:0] cnt_dec;
    logic          take;

    brl_cond_eval u_cond (
        .code (sel[3:0]),
        .fs   (flag_s),
        .fz   (flag_z),
        .fo   (flag_o),
        .fc   (flag_c),
        .take (cond_take)
    );

    brl_loop_dec #(.CW(CW)) u_loop (
        .cnt_cur  (cnt_q),
        .form     (form),
        .fz       (flag_z),
        .cnt_next (cnt_dec),
        .take     (loop_take)
    );

    always_comb begin
        is_cond = ~sel[4];
        is_loop = (sel == SEL_LOOP) || (sel == SEL_LOOPE) || (sel == SEL_LOOPNE);
        case (sel)
            SEL_LOOPE:  form = LF_WHILEZ;
            SEL_LOOPNE: form = LF_WHILENZ;
            default:    form = LF_PLAIN;
        endcase
        if (is_cond)      take = cond_take;
        else if (is_loop) take = loop_take;
        else              take = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q    <= '0;
            cnt_q   <= '0;
            we_q    <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            we_q    <= 1'b0;
            if (cnt_ld) begin
                cnt_q <= cnt_ld_val;
            end else if (en) begin
                ip_q <= take ? tgt_addr : seq_addr;
                if (is_loop) begin
                    cnt_q <= cnt_dec;
                    we_q  <= 1'b1;
                end
            end
        end
    end

    assign next_ip  = ip_q;
    assign count    = cnt_q;
    assign count_we = we_q;

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!en && !cnt_ld && rst_n)) |-> ($stable(ip_q) && $stable(cnt_q) && !we_q));

    p_loop_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(en && !cnt_ld && is_loop && rst_n)) |-> (cnt_q == $past(cnt_q) - CW'(1)));

    p_we_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> (past_ok && $past(en && !cnt_ld && is_loop)));

    p_never_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(en && !cnt_ld && sel == 5'd15 && rst_n)) |-> (ip_q == $past(seq_addr)));

    p_exhaust_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(en && !cnt_ld && is_loop && rst_n) && cnt_q == '0) |-> (ip_q == $past(seq_addr)));

    p_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cnt_ld && rst_n)) |-> (cnt_q == $past(cnt_ld_val) && $stable(ip_q)));
endmodule

// File: tb/sim_brl_unit.sv
module sim_brl_unit;
    localparam int AW = 32;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [4:0]    sel = '0;
    logic          flag_s = 1'b0, flag_z = 1'b0, flag_o = 1'b0, flag_c = 1'b0;
    logic [AW-1:0] seq_addr = '0, tgt_addr = '0;
    logic          cnt_ld = 1'b0;
    logic [CW-1:0] cnt_ld_val = '0;
    logic [AW-1:0] next_ip;
    logic [CW-1:0] count;
    logic          count_we;

    longint        m_ip = 0;
    longint        m_cnt = 0;
    bit            m_we = 0;
    int            n_chk = 0;
    int            n_bad = 0;

    always #5 clk = ~clk;

    brl_unit #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .sel(sel),
        .flag_s(flag_s), .flag_z(flag_z), .flag_o(flag_o), .flag_c(flag_c),
        .seq_addr(seq_addr), .tgt_addr(tgt_addr),
        .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val),
        .next_ip(next_ip), .count(count), .count_we(count_we)
    );

    function automatic bit ref_cond(int code, bit s, bit z, bit o, bit c);
        bit signed_less;
        signed_less = (s != o);
        case (code)
            0:  return s == 1;
            1:  return s == 0;
            2:  return z == 1;
            3:  return z == 0;
            4:  return o == 1;
            5:  return o == 0;
            6:  return c == 1;
            7:  return c == 0;
            8:  return !c && !z;
            9:  return c || z;
            10: return signed_less;
            11: return !signed_less;
            12: return !z && !signed_less;
            13: return z || signed_less;
            14: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int code);
        if (code < 8)        return "R2";
        else if (code < 10)  return "R3";
        else if (code < 12)  return "R4";
        else if (code < 14)  return "R5";
        else if (code < 16)  return "R6";
        else if (code == 16) return "R7";
        else if (code == 17) return "R8";
        else if (code == 18) return "R9";
        else                 return "R12";
    endfunction

    task automatic compare(string req);
        n_chk++;
        if (next_ip !== AW'(m_ip) || count !== CW'(m_cnt) || count_we !== m_we) begin
            n_bad++;
            $display("FAIL %s: ip=%h cnt=%h we=%b expected ip=%h cnt=%h we=%b",
                     req, next_ip, count, count_we, AW'(m_ip), CW'(m_cnt), m_we);
        end
    endtask

    task automatic step(bit e, int code, bit [3:0] f, bit ld, longint ldv, string req);
        bit t;
        longint nc;
        en = e; sel = 5'(code);
        {flag_s, flag_z, flag_o, flag_c} = f;
        cnt_ld = ld; cnt_ld_val = CW'(ldv);
        seq_addr = seq_addr + 4;
        tgt_addr = tgt_addr + 32'h0001_0010;
        @(posedge clk);
        m_we = 0;
        if (ld) begin
            m_cnt = ldv;
        end else if (e) begin
            t = 0;
            if (code < 16) begin
                t = ref_cond(code, f[3], f[2], f[1], f[0]);
            end else if (code <= 18) begin
                nc = (m_cnt + 64'hFFFF_FFFF) % 64'h1_0000_0000;
                t = (nc != 0) && (code == 16 || (code == 17 && f[2]) || (code == 18 && !f[2]));
                m_cnt = nc;
                m_we = 1;
            end
            m_ip = t ? longint'(tgt_addr) : longint'(seq_addr);
        end
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: ip=%h cnt=%h we=%b expected run end", next_ip, count, count_we);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        seq_addr = 32'h0000_4000;
        tgt_addr = 32'h0080_0000;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        for (int code = 0; code < 16; code++)
            for (int f = 0; f < 16; f++)
                step(1, code, 4'(f), 0, 0, tag_of(code));

        step(1, 0, 4'b0000, 1, 3, "R13");
        step(1, 16, 4'b0000, 0, 0, "R7");
        step(1, 16, 4'b0100, 0, 0, "R7");
        step(1, 16, 4'b0000, 0, 0, "R10");

        step(0, 0, 4'b0000, 1, 0, "R13");
        step(1, 16, 4'b0000, 0, 0, "R10");
        step(0, 16, 4'b1111, 0, 0, "R11");
        step(0, 14, 4'b0000, 0, 0, "R11");

        step(0, 0, 4'b0000, 1, 4, "R13");
        step(1, 17, 4'b0100, 0, 0, "R8");
        step(1, 17, 4'b0000, 0, 0, "R8");
        step(1, 17, 4'b0100, 0, 0, "R8");
        step(1, 17, 4'b0100, 0, 0, "R10");

        step(0, 0, 4'b0000, 1, 4, "R13");
        step(1, 18, 4'b0000, 0, 0, "R9");
        step(1, 18, 4'b0100, 0, 0, "R9");
        step(1, 18, 4'b1011, 0, 0, "R9");
        step(1, 18, 4'b0000, 0, 0, "R10");

        for (int code = 19; code < 32; code++)
            step(1, code, 4'b1111, 0, 0, "R12");
        step(1, 14, 4'b0000, 1, 77, "R13");
        step(1, 16, 4'b0000, 1, 9, "R13");
        step(1, 16, 4'b0000, 0, 0, "R12");
        step(1, 2, 4'b0100, 0, 0, "R12");

        rst_n = 1'b0;
        m_ip = 0; m_cnt = 0; m_we = 0;
        @(negedge clk);
        compare("R1");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule